// File: doc/BRIEF.md
# Set/Clear Mask Interrupt Controller

This block collects eight level-sensitive interrupt lines and combines them into one request to the processor. Each line can reach the request only while its enable bit in an internal mask is set. Software never writes the mask as a whole. One write location ORs one-bits into the mask, and a second location removes the enables at the one-bits written. Zero bits written to either location leave the mask untouched.

The same two locations are also read. The first returns the mask, and the second returns the pending status, which is the live input levels ANDed with the mask. Besides the combined request, the block reports the number of the lowest-numbered pending line together with a valid flag. The number is found by a halving search: first the low half of the status is tested, then the low quarter of what remains, then the low bit. A source is quieted by clearing its enable; there is no edge capture and no acknowledge.

The bus is a synchronous single-cycle port: one select bit, a write strobe, a read strobe and an 8-bit data path. All outputs are registered.

Top module: `irq_mask_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the mask to 0x00 and drives irq_req, pend_vld, pend_idx and bus_rdata to 0.
- R2: A write with bus_sel=0 ORs bus_wdata into the mask at that clock edge; writing 0x00 leaves the mask unchanged.
- R3: A write with bus_sel=1 clears every mask bit where bus_wdata is one; writing 0xFF disables all sources.
- R4: A read with bus_sel=0 loads the mask into bus_rdata at that edge; when bus_rd is low, bus_rdata holds its value.
- R5: A read with bus_sel=1 loads irq_in AND mask into bus_rdata at that edge.
- R6: irq_req is the OR of (irq_in AND mask) as sampled at the previous clock edge.
- R7: pend_vld equals irq_req, and pend_idx is the number of the lowest set bit of (irq_in AND mask) at the previous edge, or 0 when no bit is set.
- R8: Inputs are level-sensitive: a pending source stops requesting when its line goes low or its mask bit is cleared, with no stored state.
- R9: After a clear of 0xFF, a set of 0x55 and a set of 0x00, a mask read returns 0x55.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Location select: 0 = set/mask, 1 = clear/status |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_in | input | 8 | Level-sensitive interrupt lines, bit n is source n |
| irq_req | output | 1 | Combined interrupt request |
| pend_idx | output | 3 | Lowest-numbered pending source |
| pend_vld | output | 1 | Some source is pending |

## Verification
Every cycle the assertions check the mask updates for set and clear writes, the request and valid flag against the previous cycle's masked inputs, that the reported index is a pending bit with no lower pending bit, that a mask read returns the prior mask, and the reset state. Only the bench scenarios show whole sequences: the 0x55 enable pattern surviving a null set, status readback under changing line patterns, the idx of 0 when nothing pends, and a source falling silent when its line drops or its enable is removed.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  typedef enum logic {
    LOC_MASK  = 1'b0,
    LOC_CLEAR = 1'b1
  } loc_e;
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_stb,
  input  logic             clr_stb,
  input  logic [N_IRQ-1:0] wdata,
  output logic [N_IRQ-1:0] mask_q
);
  logic [N_IRQ-1:0] set_vec;
  logic [N_IRQ-1:0] clr_vec;
  logic [N_IRQ-1:0] mask_d;

  assign set_vec = set_stb ? wdata : '0;
  assign clr_vec = clr_stb ? wdata : '0;

  // per-bit update, clear takes precedence over set on the same bit
  for (genvar b = 0; b < N_IRQ; b++) begin : g_bit
    always_comb begin
      if (clr_vec[b])      mask_d[b] = 1'b0;
      else if (set_vec[b]) mask_d[b] = 1'b1;
      else                 mask_d[b] = mask_q[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_d;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N_IRQ = 8,
  localparam int IDX_W = $clog2(N_IRQ)
) (
  input  logic [N_IRQ-1:0] stat,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  logic [N_IRQ-1:0] sv [0:IDX_W];
  logic [IDX_W-1:0] si [0:IDX_W];

  assign sv[0] = stat;
  assign si[0] = '0;

  // halving search: test the low half, shift past it when empty
  for (genvar g = 0; g < IDX_W; g++) begin : g_stage
    localparam int HALF = 1 << (IDX_W - 1 - g);
    localparam logic [N_IRQ-1:0] LOW = {N_IRQ{1'b1}} >> (N_IRQ - HALF);
    logic empty;
    assign empty     = (sv[g] & LOW) == '0;
    assign sv[g+1]   = empty ? (sv[g] >> HALF) : sv[g];
    assign si[g+1]   = empty ? (si[g] | IDX_W'(HALF)) : si[g];
  end

  assign any = |stat;
  assign idx = any ? si[IDX_W] : '0;
endmodule

// File: rtl/irq_bus_read.sv
module irq_bus_read #(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_stb,
  input  logic             sel,
  input  logic [N_IRQ-1:0] mask_q,
  input  logic [N_IRQ-1:0] stat,
  output logic [N_IRQ-1:0] rdata
);
  import irq_mask_pkg::*;

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_stb) rdata <= (loc_e'(sel) == LOC_CLEAR) ? stat : mask_q;
  end
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl #(
  parameter int N_IRQ = 8,
  localparam int IDX_W = $clog2(N_IRQ)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [N_IRQ-1:0] bus_wdata,
  output logic [N_IRQ-1:0] bus_rdata,
  input  logic [N_IRQ-1:0] irq_in,
  output logic             irq_req,
  output logic [IDX_W-1:0] pend_idx,
  output logic             pend_vld
);
  import irq_mask_pkg::*;

  logic [N_IRQ-1:0] mask_q;
  logic [N_IRQ-1:0] stat;
  logic [IDX_W-1:0] enc_idx;
  logic             enc_any;
  logic             set_stb;
  logic             clr_stb;

  assign set_stb = bus_wr && (loc_e'(bus_sel) == LOC_MASK);
  assign clr_stb = bus_wr && (loc_e'(bus_sel) == LOC_CLEAR);
  assign stat    = irq_in & mask_q;

  irq_mask_reg #(.N_IRQ(N_IRQ)) u_mask (
    .clk(clk), .rst(rst), .set_stb(set_stb), .clr_stb(clr_stb),
    .wdata(bus_wdata), .mask_q(mask_q)
  );

  irq_prio_enc #(.N_IRQ(N_IRQ)) u_enc (
    .stat(stat), .idx(enc_idx), .any(enc_any)
  );

  irq_bus_read #(.N_IRQ(N_IRQ)) u_rd (
    .clk(clk), .rst(rst), .rd_stb(bus_rd), .sel(bus_sel),
    .mask_q(mask_q), .stat(stat), .rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req  <= 1'b0;
      pend_vld <= 1'b0;
      pend_idx <= '0;
    end else begin
      irq_req  <= |stat;
      pend_vld <= enc_any;
      pend_idx <= enc_idx;
    end
  end
endmodule

// File: rtl/irq_mask_ctrl_chk.sv
module irq_mask_ctrl_chk #(
  parameter int N_IRQ = 8,
  localparam int IDX_W = $clog2(N_IRQ)
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [N_IRQ-1:0] bus_wdata,
  input logic [N_IRQ-1:0] bus_rdata,
  input logic [N_IRQ-1:0] irq_in,
  input logic             irq_req,
  input logic [IDX_W-1:0] pend_idx,
  input logic             pend_vld,
  input logic [N_IRQ-1:0] mask_q
);
  logic [N_IRQ-1:0] below;
  assign below = (N_IRQ'(1) << pend_idx) - N_IRQ'(1);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (mask_q == '0 && !irq_req && !pend_vld && pend_idx == '0 && bus_rdata == '0));

  a_r2_set_or: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_sel) |=> (mask_q == ($past(mask_q) | $past(bus_wdata))));

  a_r3_clear_bits: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_sel) |=> (mask_q == ($past(mask_q) & ~$past(bus_wdata))));

  a_r4_mask_read: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_sel) |=> (bus_rdata == $past(mask_q)));

  a_r5_status_read: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_sel) |=> (bus_rdata == ($past(irq_in) & $past(mask_q))));

  a_r6_request: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_req == |($past(irq_in) & $past(mask_q))));

  a_r7_valid: assert property (@(posedge clk) disable iff (rst)
    pend_vld == irq_req);

  a_r7_lowest: assert property (@(posedge clk) disable iff (rst)
    pend_vld |-> ((($past(irq_in) & $past(mask_q)) >> pend_idx) & N_IRQ'(1)) != '0
                 && (($past(irq_in) & $past(mask_q)) & below) == '0);

  a_r7_idle_idx: assert property (@(posedge clk) disable iff (rst)
    !pend_vld |-> pend_idx == '0);
endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
  .irq_req(irq_req), .pend_idx(pend_idx), .pend_vld(pend_vld), .mask_q(mask_q)
);

// File: tb/irq_mask_ctrl_tb.sv
module irq_mask_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] irq_in = '0;
  logic       irq_req;
  logic [2:0] pend_idx;
  logic       pend_vld;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  irq_mask_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .irq_req(irq_req), .pend_idx(pend_idx), .pend_vld(pend_vld)
  );

  // {wr, rd, sel, wdata, lines, exp_rdata, exp_req, exp_idx, exp_vld}
  localparam int NV = 14;
  localparam logic [31:0] VEC [0:NV-1] = '{
    {1'b1,1'b0,1'b1,8'hFF,8'hFF,8'h00,1'b0,3'd0,1'b0}, // R3 clear all
    {1'b1,1'b0,1'b0,8'h55,8'h00,8'h00,1'b0,3'd0,1'b0}, // R2 set 55
    {1'b1,1'b0,1'b0,8'h00,8'h00,8'h00,1'b0,3'd0,1'b0}, // R2 set 00
    {1'b0,1'b1,1'b0,8'h00,8'h00,8'h55,1'b0,3'd0,1'b0}, // R9 read mask 55
    {1'b0,1'b1,1'b1,8'h00,8'hFF,8'h55,1'b1,3'd0,1'b1}, // R5 R6 R7
    {1'b0,1'b1,1'b1,8'h00,8'hAA,8'h00,1'b0,3'd0,1'b0}, // R7 none pending
    {1'b0,1'b1,1'b1,8'h00,8'hF0,8'h50,1'b1,3'd4,1'b1}, // R7 idx 4
    {1'b1,1'b0,1'b0,8'h80,8'h80,8'h50,1'b1,3'd7,1'b1}, // R2 R4 hold
    {1'b1,1'b0,1'b1,8'h10,8'h0C,8'h50,1'b1,3'd2,1'b1}, // R3 partial
    {1'b0,1'b1,1'b0,8'h00,8'h0C,8'hC5,1'b1,3'd2,1'b1}, // R4 mask C5
    {1'b0,1'b0,1'b0,8'h00,8'h08,8'hC5,1'b0,3'd0,1'b0}, // R8 line drop
    {1'b1,1'b0,1'b1,8'hFF,8'hFF,8'hC5,1'b0,3'd0,1'b0}, // R3 R8 clear all
    {1'b0,1'b1,1'b1,8'h00,8'hFF,8'h00,1'b0,3'd0,1'b0}, // R5 zero status
    {1'b1,1'b0,1'b0,8'h08,8'h08,8'h00,1'b1,3'd3,1'b1}  // R2 R7 idx 3
  };

  task automatic check_outs(input string tag, input logic [7:0] erd,
                            input logic ereq, input logic [2:0] eidx, input logic evld);
    n_vec++;
    if (bus_rdata !== erd || irq_req !== ereq || pend_idx !== eidx || pend_vld !== evld) begin
      n_bad++;
      $display("FAIL %s: rdata=%h req=%b idx=%0d vld=%b expected rdata=%h req=%b idx=%0d vld=%b",
               tag, bus_rdata, irq_req, pend_idx, pend_vld, erd, ereq, eidx, evld);
    end
  endtask

  task automatic apply(input logic wr, input logic rd, input logic sel,
                       input logic [7:0] wd, input logic [7:0] lines);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_sel = sel; bus_wdata = wd; irq_in = lines;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    #100000;
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_outs("R1 reset state", 8'h00, 1'b0, 3'd0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      apply(v[31], v[30], v[29], v[28:21], v[20:13]);
      check_outs($sformatf("vector %0d R2-group", i), v[12:5], v[4], v[3:1], v[0]);
    end

    // R8: removing the enable silences a high line
    apply(1'b1, 1'b0, 1'b1, 8'h08, 8'h08);
    check_outs("R8 enable removed", 8'h00, 1'b0, 3'd0, 1'b0);

    // R7: simultaneous lines, lowest wins
    apply(1'b1, 1'b0, 1'b0, 8'hFF, 8'hFE);
    check_outs("R7 lowest of many", 8'h00, 1'b1, 3'd1, 1'b1);
    apply(1'b0, 1'b0, 1'b0, 8'h00, 8'h80);
    check_outs("R7 only top bit", 8'h00, 1'b1, 3'd7, 1'b1);

    // R1: reset mid-operation clears the mask
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check_outs("R1 reset outputs", 8'h00, 1'b0, 3'd0, 1'b0);
    apply(1'b0, 1'b1, 1'b0, 8'h00, 8'hFF);
    check_outs("R1 mask cleared by reset", 8'h00, 1'b0, 3'd0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule